// File: doc/BRIEF.md
# Flash Sector-Programming Sequencer

This block sits between a host and a register-style flash port. The port has two 32-bit registers. The address register carries a completion flag in its top bit. The data register holds the dword being written or read back. The sequencer runs three commands: an identification read, a single-dword read, and a multi-dword program. Every register access ends with a flag handshake, and each access has its own poll limit. The sequencer also owns the global flash-enable bit.

The program command streams dwords from the host through a valid/ready handshake. Before each dword that starts a sector, the sequencer issues a sector erase on its own. The sector size and the erase command address come from the manufacturer and device bytes captured by the most recent successful identification. After reset these bytes are zero, which selects the default geometry. The erase data is the sector base shifted left by two, with its bytes rearranged. Around the whole program run the sequencer raises the enable bit and lifts write protection first, and it drops the enable bit at the end whether the run succeeded or not.

State machine. The states are S_IDLE, S_IDENT, S_READ, S_UNPROT, S_CHECK, S_ERASE, S_WDATA, S_PROG, S_DISABLE and S_FIN.
- From S_IDLE, an accepted command goes to S_IDENT (op 0), S_READ (op 1) or S_UNPROT (op 2).
- S_IDENT and S_READ go to S_FIN when their access completes.
- S_UNPROT goes to S_CHECK when its access completes.
- S_CHECK goes to S_DISABLE when no dwords remain, to S_ERASE at a sector boundary, and to S_WDATA otherwise.
- S_ERASE goes to S_WDATA on success and to S_DISABLE on failure.
- S_WDATA goes to S_PROG once a dword is accepted.
- S_PROG goes back to S_CHECK on success and to S_DISABLE on failure.
- S_DISABLE goes to S_FIN, and S_FIN returns to S_IDLE.

The access engine below the sequencer has four states: A_IDLE, A_DATA (writes only), A_ADDR and A_POLL.

Top module: `flash_seq`

## Requirements
- R1: After reset, flash_en is 0, done is 0, cmd_ready is 1 and neither port write strobe is active. Commands are accepted only while cmd_ready is 1.
- R2: A read writes the address register with bit 31 (the flag) at 0, bits 29:28 at the space select (2'b10 for data space, 2'b01 for configuration space), bits 27:20 at 0 and bits 19:0 at the dword address. It then polls until the flag reads 1 and returns the data register with status 2'b00.
- R3: If the flag is not seen set within RD_POLL_LIMIT samples, the read returns 0xDEADDEAD with status 2'b01.
- R4: A write loads the data register in the cycle before an address-register write that has the flag at 1. The write completes when the flag reads 0.
- R5: If the flag does not clear within WR_POLL_LIMIT samples, the write fails. Program ends with status 2'b10 and makes no further port writes.
- R6: Identification (op 0) reads data-space address 0xD03AB. It captures bits 7:0 as the manufacturer ID on id_man and bits 15:8 as the device ID on id_dev.
- R7: With manufacturer 0xBF, a sector starts where addr & 0x1FFF is 0, and the sector mask is 0x3E000. For any other manufacturer the offset mask is 0x3FFF and the sector mask is 0x3C000.
- R8: The erase goes to configuration address 0x3D8, except that manufacturer 0xBF with device 0x80 uses 0x352.
- R9: The erase data is built from v = (addr & sector mask) << 2. Bits 15:8 of v stay in place, bits 7:0 of v move to bits 23:16, and bits 23:16 of v move to bits 7:0. The other bits are 0.
- R10: Program (op 2) raises flash_en and first writes 0 to configuration address 0x101. It then writes each dword to consecutive data-space addresses. flash_en is 0 again when done pulses.
- R11: Program stops at the first failed erase or data write, and flash_en is still cleared.
- R12: wr_ready is high only while the sequencer waits for the next dword. That is only after the previous write's flag has cleared, and it drops the cycle after a handshake.
- R13: done is a one-cycle pulse, with status and rd_data valid in that cycle. cmd_ready returns on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken while cmd_ready |
| cmd_op | input | 2 | 0 identify, 1 read, 2 program |
| cmd_addr | input | 20 | Start dword address |
| cmd_count | input | 16 | Dwords to program |
| cmd_ready | output | 1 | Sequencer idle |
| wr_ready | output | 1 | Requests the next program dword |
| wr_valid | input | 1 | Host offers a dword |
| wr_data | input | 32 | Program dword |
| done | output | 1 | Command finished pulse |
| status | output | 2 | 00 ok, 01 read timeout, 10 write failure |
| rd_data | output | 32 | Read result |
| id_man | output | 8 | Captured manufacturer ID |
| id_dev | output | 8 | Captured device ID |
| flash_en | output | 1 | Global flash write enable |
| fp_addr_we | output | 1 | Address register write strobe |
| fp_addr_wd | output | 32 | Address register write value |
| fp_data_we | output | 1 | Data register write strobe |
| fp_data_wd | output | 32 | Data register write value |
| fp_flag | input | 1 | Completion flag read back |
| fp_rdata | input | 32 | Data register read back |

## Verification
A wrong geometry or stale ID state shows up at the sector boundary inside the same command. An erase appears where none belongs, or is missing, or carries the wrong address or byte order, and the address-write log exposes it at once. A wrong poll counter or flag direction shows up within one poll window: the port sees a premature next write, or a completion arrives without the flag change. A leaked enable or failure state shows at the done pulse, through flash_en, status or a write after the failure.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    localparam int AW = 20;

    localparam logic [1:0] OP_IDENT = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_PROG  = 2'd2;

    localparam logic [1:0] SP_DATA = 2'b10;
    localparam logic [1:0] SP_CONF = 2'b01;

    localparam logic [1:0] ST_OK      = 2'b00;
    localparam logic [1:0] ST_RD_TMO  = 2'b01;
    localparam logic [1:0] ST_WR_FAIL = 2'b10;

    localparam logic [AW-1:0] ID_ADDR     = 20'hD03AB;
    localparam logic [AW-1:0] UNPROT_ADDR = 20'h00101;
    localparam logic [AW-1:0] ERASE_STD   = 20'h003D8;
    localparam logic [AW-1:0] ERASE_ALT   = 20'h00352;
    localparam logic [7:0]    MAN_SMALL   = 8'hBF;
    localparam logic [7:0]    DEV_ALT     = 8'h80;
    localparam logic [31:0]   RD_FAIL_VAL = 32'hDEADDEAD;

    function automatic logic [31:0] port_addr(input logic [1:0] space,
                                              input logic [AW-1:0] a);
        return {2'b00, space, 8'h00, a};
    endfunction
endpackage

// File: rtl/flash_seq_access.sv
module flash_seq_access
    import flash_seq_pkg::*;
#(
    parameter int RD_LIMIT = 3000,
    parameter int WR_LIMIT = 500000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        is_wr,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic        fp_addr_we,
    output logic [31:0] fp_addr_wd,
    output logic        fp_data_we,
    output logic [31:0] fp_data_wd,
    input  logic        fp_flag,
    input  logic [31:0] fp_rdata,
    output logic        acc_done,
    output logic        acc_ok,
    output logic [31:0] acc_rdata
);
    localparam int MAXL = (RD_LIMIT > WR_LIMIT) ? RD_LIMIT : WR_LIMIT;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] RD_LAST = CW'(RD_LIMIT - 1);
    localparam logic [CW-1:0] WR_LAST = CW'(WR_LIMIT - 1);

    typedef enum logic [1:0] {A_IDLE, A_DATA, A_ADDR, A_POLL} acc_state_e;

    acc_state_e st, st_nx;
    logic [CW-1:0] cnt;
    logic hit, last;

    assign hit  = is_wr ? !fp_flag : fp_flag;
    assign last = (cnt == (is_wr ? WR_LAST : RD_LAST));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= A_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st == A_ADDR)      cnt <= '0;
            else if (st == A_POLL) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            A_IDLE: if (go) st_nx = is_wr ? A_DATA : A_ADDR;
            A_DATA: st_nx = A_ADDR;
            A_ADDR: st_nx = A_POLL;
            A_POLL: if (hit || last) st_nx = A_IDLE;
            default: st_nx = A_IDLE;
        endcase
    end

    always_comb begin
        fp_data_we = (st == A_DATA);
        fp_data_wd = wdata;
        fp_addr_we = (st == A_ADDR);
        fp_addr_wd = {is_wr, addr[30:0]};
        acc_done   = (st == A_POLL) && (hit || last);
        acc_ok     = hit;
        acc_rdata  = hit ? fp_rdata : RD_FAIL_VAL;
    end
endmodule

// File: rtl/flash_seq_geom.sv
module flash_seq_geom
    import flash_seq_pkg::*;
(
    input  logic [7:0]    man,
    input  logic [7:0]    dev,
    input  logic [AW-1:0] addr,
    output logic          at_bound,
    output logic [AW-1:0] erase_addr,
    output logic [31:0]   erase_data
);
    logic [AW-1:0] off_mask, sec_mask;
    logic [23:0]   v;

    always_comb begin
        if (man == MAN_SMALL) begin
            off_mask = 20'h01FFF;
            sec_mask = 20'h3E000;
        end else begin
            off_mask = 20'h03FFF;
            sec_mask = 20'h3C000;
        end
        erase_addr = (man == MAN_SMALL && dev == DEV_ALT) ? ERASE_ALT : ERASE_STD;
        at_bound   = ((addr & off_mask) == '0);
        v          = {4'h0, addr & sec_mask} << 2;
        erase_data = {8'h00, v[7:0], v[15:8], v[23:16]};
    end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int RD_POLL_LIMIT = 3000,
    parameter int WR_POLL_LIMIT = 500000,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             cmd_ready,
    output logic             wr_ready,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    output logic             done,
    output logic [1:0]       status,
    output logic [31:0]      rd_data,
    output logic [7:0]       id_man,
    output logic [7:0]       id_dev,
    output logic             flash_en,
    output logic             fp_addr_we,
    output logic [31:0]      fp_addr_wd,
    output logic             fp_data_we,
    output logic [31:0]      fp_data_wd,
    input  logic             fp_flag,
    input  logic [31:0]      fp_rdata
);
    typedef enum logic [3:0] {
        S_IDLE, S_IDENT, S_READ, S_UNPROT, S_CHECK,
        S_ERASE, S_WDATA, S_PROG, S_DISABLE, S_FIN
    } seq_state_e;

    seq_state_e st, st_nx;
    logic [AW-1:0]    cur_addr;
    logic [CNT_W-1:0] remain;
    logic [31:0]      dword_q, rd_q;
    logic [1:0]       stat_q;
    logic [7:0]       man_q, dev_q;
    logic             en_q;

    logic          acc_go, acc_wr, acc_done, acc_ok;
    logic [31:0]   acc_addr, acc_wdata, acc_rdata;
    logic          at_bound;
    logic [AW-1:0] erase_addr;
    logic [31:0]   erase_data;

    flash_seq_geom u_geom (
        .man(man_q), .dev(dev_q), .addr(cur_addr),
        .at_bound(at_bound), .erase_addr(erase_addr), .erase_data(erase_data)
    );

    flash_seq_access #(.RD_LIMIT(RD_POLL_LIMIT), .WR_LIMIT(WR_POLL_LIMIT)) u_acc (
        .clk(clk), .rst_n(rst_n), .go(acc_go), .is_wr(acc_wr),
        .addr(acc_addr), .wdata(acc_wdata),
        .fp_addr_we(fp_addr_we), .fp_addr_wd(fp_addr_wd),
        .fp_data_we(fp_data_we), .fp_data_wd(fp_data_wd),
        .fp_flag(fp_flag), .fp_rdata(fp_rdata),
        .acc_done(acc_done), .acc_ok(acc_ok), .acc_rdata(acc_rdata)
    );

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (cmd_valid) begin
                if (cmd_op == OP_IDENT)     st_nx = S_IDENT;
                else if (cmd_op == OP_READ) st_nx = S_READ;
                else if (cmd_op == OP_PROG) st_nx = S_UNPROT;
            end
            S_IDENT, S_READ: if (acc_done) st_nx = S_FIN;
            S_UNPROT: if (acc_done) st_nx = S_CHECK;
            S_CHECK: begin
                if (remain == '0)  st_nx = S_DISABLE;
                else if (at_bound) st_nx = S_ERASE;
                else               st_nx = S_WDATA;
            end
            S_ERASE: if (acc_done) st_nx = acc_ok ? S_WDATA : S_DISABLE;
            S_WDATA: if (wr_valid) st_nx = S_PROG;
            S_PROG:  if (acc_done) st_nx = acc_ok ? S_CHECK : S_DISABLE;
            S_DISABLE: st_nx = S_FIN;
            S_FIN:     st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            dword_q  <= '0;
            rd_q     <= '0;
            stat_q   <= ST_OK;
            man_q    <= '0;
            dev_q    <= '0;
            en_q     <= 1'b0;
        end else begin
            st <= st_nx;
            unique case (st)
                S_IDLE: if (cmd_valid) begin
                    cur_addr <= cmd_addr;
                    remain   <= cmd_count;
                    stat_q   <= ST_OK;
                    if (cmd_op == OP_PROG) en_q <= 1'b1;
                end
                S_IDENT, S_READ: if (acc_done) begin
                    rd_q   <= acc_rdata;
                    stat_q <= acc_ok ? ST_OK : ST_RD_TMO;
                    if (st == S_IDENT && acc_ok) begin
                        man_q <= acc_rdata[7:0];
                        dev_q <= acc_rdata[15:8];
                    end
                end
                S_ERASE: if (acc_done && !acc_ok) stat_q <= ST_WR_FAIL;
                S_WDATA: if (wr_valid) dword_q <= wr_data;
                S_PROG: if (acc_done) begin
                    if (acc_ok) begin
                        cur_addr <= cur_addr + 1'b1;
                        remain   <= remain - 1'b1;
                    end else begin
                        stat_q <= ST_WR_FAIL;
                    end
                end
                S_DISABLE: en_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (st == S_IDLE);
        wr_ready  = (st == S_WDATA);
        done      = (st == S_FIN);
        status    = stat_q;
        rd_data   = rd_q;
        id_man    = man_q;
        id_dev    = dev_q;
        flash_en  = en_q;
        acc_go    = 1'b0;
        acc_wr    = 1'b1;
        acc_addr  = '0;
        acc_wdata = '0;
        unique case (st)
            S_IDENT: begin
                acc_go = 1'b1; acc_wr = 1'b0;
                acc_addr = port_addr(SP_DATA, ID_ADDR);
            end
            S_READ: begin
                acc_go = 1'b1; acc_wr = 1'b0;
                acc_addr = port_addr(SP_DATA, cur_addr);
            end
            S_UNPROT: begin
                acc_go = 1'b1;
                acc_addr = port_addr(SP_CONF, UNPROT_ADDR);
            end
            S_ERASE: begin
                acc_go = 1'b1;
                acc_addr  = port_addr(SP_CONF, erase_addr);
                acc_wdata = erase_data;
            end
            S_PROG: begin
                acc_go = 1'b1;
                acc_addr  = port_addr(SP_DATA, cur_addr);
                acc_wdata = dword_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        wr_ready,
    input logic        wr_valid,
    input logic        done,
    input logic        flash_en,
    input logic        fp_addr_we,
    input logic [31:0] fp_addr_wd,
    input logic        fp_data_we
);
    // R4: data register loaded in the cycle before a flagged address write
    a_r4_data_before_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_addr_we && fp_addr_wd[31]) |-> $past(fp_data_we));

    // R10: any data-space write happens with the enable bit raised
    a_r10_en_on_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_addr_we && fp_addr_wd[31] && fp_addr_wd[29:28] == 2'b10) |-> flash_en);

    // R10 / R11: enable bit is low when a command completes
    a_r11_en_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flash_en);

    // R13: done lasts a single cycle and idle follows
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready));

    // R12: one dword per request
    a_r12_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && wr_valid) |=> !wr_ready);

    // R2 / R4: address writes are isolated single-cycle strobes
    a_r2_addr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        fp_addr_we |=> !fp_addr_we);
endmodule

bind flash_seq flash_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .done(done), .flash_en(flash_en),
    .fp_addr_we(fp_addr_we), .fp_addr_wd(fp_addr_wd), .fp_data_we(fp_data_we)
);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RDL = 20;
    localparam int WRL = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [19:0] cmd_addr = '0;
    logic [15:0] cmd_count = '0;
    logic        cmd_ready, wr_ready, wr_valid, done, flash_en;
    logic [31:0] wr_data, rd_data;
    logic [1:0]  status;
    logic [7:0]  id_man, id_dev;
    logic        fp_addr_we, fp_data_we, fp_flag;
    logic [31:0] fp_addr_wd, fp_data_wd, fp_rdata;

    flash_seq #(.RD_POLL_LIMIT(RDL), .WR_POLL_LIMIT(WRL)) u_flash_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_ready(cmd_ready),
        .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_data(wr_data),
        .done(done), .status(status), .rd_data(rd_data), .id_man(id_man),
        .id_dev(id_dev), .flash_en(flash_en), .fp_addr_we(fp_addr_we),
        .fp_addr_wd(fp_addr_wd), .fp_data_we(fp_data_we), .fp_data_wd(fp_data_wd),
        .fp_flag(fp_flag), .fp_rdata(fp_rdata)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // ---------------- port model ----------------
    logic [31:0] areg = '0, dreg = '0;
    logic        flag = 1'b0, busy = 1'b0;
    int          dly = 0;
    int          resp_dly = 3;
    int          stuck_from = 1000;
    logic [31:0] id_word = 32'h0;
    logic [31:0] log_a [64];
    logic [31:0] log_d [64];
    int          log_n = 0;
    int          bad_ready = 0;

    assign fp_flag  = flag;
    assign fp_rdata = (areg[19:0] == 20'hD03AB) ? id_word : {12'hA5A, areg[19:0]};

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (wr_ready && (flag || busy)) bad_ready <= bad_ready + 1;
        if (fp_data_we) dreg <= fp_data_wd;
        if (fp_addr_we) begin
            areg <= fp_addr_wd;
            flag <= fp_addr_wd[31];
            if (log_n < 64) begin
                log_a[log_n] <= fp_addr_wd;
                log_d[log_n] <= dreg;
            end
            log_n <= log_n + 1;
            busy  <= (log_n < stuck_from);
            dly   <= resp_dly;
        end else if (busy) begin
            if (dly == 0) begin
                flag <= ~flag;
                busy <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end
    end

    // ---------------- host data feed ----------------
    logic [31:0] feed [64];
    int acc_cnt = 0, feed_base = 0, rcnt = 0, gap = 0;
    logic feed_on = 1'b0;
    assign wr_valid = feed_on && (rcnt >= gap);
    assign wr_data  = feed[(acc_cnt - feed_base) & 63];
    always @(posedge clk) begin
        if (wr_ready && wr_valid) begin
            acc_cnt <= acc_cnt + 1;
            rcnt    <= 0;
        end else if (wr_ready) begin
            rcnt <= rcnt + 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pa(input bit fl, input logic [1:0] sp,
                                       input logic [19:0] a);
        return {fl, 1'b0, sp, 8'h00, a};
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [19:0] a,
                           input logic [15:0] n);
        int w;
        @(negedge clk);
        chk(cmd_ready, "R13 cmd_ready before command", {31'b0, cmd_ready}, 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_count = n;
        @(negedge clk);
        cmd_valid = 1'b0;
        w = 0;
        while (!done) begin
            @(negedge clk);
            w++;
            if (w > 20000 || cycles > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog actual=hung expected=done");
                finish_run();
            end
        end
    endtask

    task automatic after_done();
        @(negedge clk);
        chk(!done && cmd_ready, "R13 done single cycle", {30'b0, done, cmd_ready}, 32'h1);
    endtask

    // expected write log for a program command
    logic [31:0] ex_a [64];
    logic [31:0] ex_d [64];
    int ex_n;

    task automatic build_prog(input logic [7:0] man, input logic [7:0] dev,
                              input logic [19:0] start, input int n);
        logic [19:0] a, off, sec, ea;
        logic [23:0] v;
        ex_n = 0;
        ex_a[ex_n] = pa(1, 2'b01, 20'h00101); ex_d[ex_n] = 0; ex_n++;
        off = (man == 8'hBF) ? 20'h01FFF : 20'h03FFF;
        sec = (man == 8'hBF) ? 20'h3E000 : 20'h3C000;
        ea  = (man == 8'hBF && dev == 8'h80) ? 20'h00352 : 20'h003D8;
        for (int i = 0; i < n; i++) begin
            a = start + 20'(i);
            if ((a & off) == 0) begin
                v = {4'h0, a & sec} << 2;
                ex_a[ex_n] = pa(1, 2'b01, ea);
                ex_d[ex_n] = {8'h0, v[7:0], v[15:8], v[23:16]};
                ex_n++;
            end
            ex_a[ex_n] = pa(1, 2'b10, a); ex_d[ex_n] = feed[i]; ex_n++;
        end
    endtask

    task automatic compare_log(input int base, input string req);
        chk(log_n - base == ex_n, {req, " write count"}, log_n - base, ex_n);
        for (int i = 0; i < ex_n && i + base < 64; i++) begin
            chk(log_a[base+i] == ex_a[i], {req, " address word"}, log_a[base+i], ex_a[i]);
            chk(log_d[base+i] == ex_d[i], {req, " data word"}, log_d[base+i], ex_d[i]);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(!flash_en, "R1 flash_en low", {31'b0, flash_en}, 0);
        chk(!done, "R1 done low", {31'b0, done}, 0);
        chk(cmd_ready, "R1 cmd_ready high", {31'b0, cmd_ready}, 1);
        chk(!fp_addr_we && !fp_data_we, "R1 no strobes", {30'b0, fp_addr_we, fp_data_we}, 0);
    endtask

    task automatic t_ident(input logic [31:0] w);
        int base;
        id_word = w;
        base = log_n;
        run_cmd(2'd0, 20'h0, 16'h0);
        chk(status == 2'b00, "R6 ident status", {30'b0, status}, 0);
        chk(id_man == w[7:0], "R6 manufacturer id", {24'b0, id_man}, {24'b0, w[7:0]});
        chk(id_dev == w[15:8], "R6 device id", {24'b0, id_dev}, {24'b0, w[15:8]});
        chk(log_a[base] == pa(0, 2'b10, 20'hD03AB), "R6 ident address",
            log_a[base], pa(0, 2'b10, 20'hD03AB));
        after_done();
    endtask

    task automatic t_read();
        int base;
        base = log_n;
        run_cmd(2'd1, 20'h00123, 16'h0);
        chk(rd_data == 32'hA5A00123, "R2 read data", rd_data, 32'hA5A00123);
        chk(status == 2'b00, "R2 read status", {30'b0, status}, 0);
        chk(log_a[base] == pa(0, 2'b10, 20'h00123), "R2 read address word",
            log_a[base], pa(0, 2'b10, 20'h00123));
        after_done();
    endtask

    task automatic t_read_timeout();
        int base;
        base = log_n;
        stuck_from = log_n;
        run_cmd(2'd1, 20'h00456, 16'h0);
        chk(rd_data == 32'hDEADDEAD, "R3 timeout value", rd_data, 32'hDEADDEAD);
        chk(status == 2'b01, "R3 timeout status", {30'b0, status}, 1);
        chk(log_n - base == 1, "R3 single access", log_n - base, 1);
        stuck_from = 1000;
        after_done();
    endtask

    task automatic t_prog(input logic [7:0] man, input logic [7:0] dev,
                          input logic [19:0] start, input int n, input int g,
                          input string req);
        int base;
        for (int i = 0; i < n; i++) feed[i] = 32'hC0DE0000 + 32'(i * 17) + {12'h0, start};
        build_prog(man, dev, start, n);
        base = log_n;
        feed_base = acc_cnt;
        gap = g;
        feed_on = 1'b1;
        bad_ready = 0;
        run_cmd(2'd2, start, 16'(n));
        feed_on = 1'b0;
        chk(status == 2'b00, {req, " status"}, {30'b0, status}, 0);
        chk(!flash_en, "R10 enable cleared at done", {31'b0, flash_en}, 0);
        chk(acc_cnt - feed_base == n, "R12 dwords accepted", acc_cnt - feed_base, n);
        chk(bad_ready == 0, "R12 ready only after flag cleared", bad_ready, 0);
        compare_log(base, req);
        after_done();
    endtask

    task automatic t_prog_fail();
        int base;
        for (int i = 0; i < 4; i++) feed[i] = 32'h5EED0000 + 32'(i);
        base = log_n;
        stuck_from = log_n + 2;
        feed_base = acc_cnt;
        gap = 0;
        feed_on = 1'b1;
        run_cmd(2'd2, 20'h00101, 16'd4);
        feed_on = 1'b0;
        chk(status == 2'b10, "R5 write failure status", {30'b0, status}, 2);
        chk(log_n - base == 3, "R11 stops after failed write", log_n - base, 3);
        chk(acc_cnt - feed_base == 2, "R11 no further dwords taken", acc_cnt - feed_base, 2);
        chk(!flash_en, "R11 enable cleared after failure", {31'b0, flash_en}, 0);
        stuck_from = 1000;
        after_done();
    endtask

    task automatic t_enable_during();
        int w;
        int seen_en;
        for (int i = 0; i < 2; i++) feed[i] = 32'h1111 * 32'(i + 1);
        feed_base = acc_cnt; gap = 2; feed_on = 1'b1;
        seen_en = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = 20'h00011; cmd_count = 16'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        w = 0;
        while (!done && w < 5000) begin
            if (fp_data_we && flash_en) seen_en++;
            @(negedge clk); w++;
        end
        feed_on = 1'b0;
        chk(seen_en == 3, "R10 enable high on every data load", seen_en, 3);
        after_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read();
        t_read_timeout();
        // R6/R7/R8/R9: small-sector part, alternate erase address
        t_ident(32'h000080BF);
        t_prog(8'hBF, 8'h80, 20'h3DFFF, 3, 0, "R9 R8 small sector");
        // R7/R8: small-sector manufacturer, other device
        t_ident(32'h000081BF);
        t_prog(8'hBF, 8'h81, 20'h02000, 2, 3, "R8 R7 standard erase address");
        // R7: other manufacturer, 16K-dword sectors
        t_ident(32'h00002013);
        t_prog(8'h13, 8'h20, 20'h03FFE, 4, 1, "R7 large sector");
        t_prog(8'h13, 8'h20, 20'h00010, 0, 0, "R10 empty program");
        t_enable_during();
        t_prog_fail();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 190000);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end
endmodule